// File: doc/BRIEF.md
# Segmented Taylor Inverse Square Root Unit

This unit takes a positive, normalized floating-point operand, given as a fraction field with an implied leading one and a signed unbiased exponent. It returns the operand's inverse square root as a normalized mantissa and a signed result exponent. The exponent is split into a halved part and a parity bit. The parity decides whether the mantissa result is scaled by two (even) or by the square root of two (odd), so that the returned mantissa always lies in [1, 2).

The mantissa function 1/√M is approximated on [1, 2). That interval is cut into eight equal segments. Within each segment the function is a five-term Taylor polynomial about the segment midpoint, evaluated in nested (Horner) form in the offset from that midpoint. The five coefficients of every segment sit in a 40-word constant table. The leading fraction bits address that table directly. A small sequencer performs one multiply-add per cycle, applies the parity scaling, then renormalizes and registers the result.

A caller raises `start_i` for one cycle with the operand applied. The unit ignores further starts until it returns to idle. It raises `done_o` for exactly one cycle when `mant_o` and `exp_o` are valid, and those outputs hold until the next result.

Top module: `isqrt_taylor_seg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o` is 0, `mant_o` is 0 and `exp_o` is 0.
- R2: For an operand with an even exponent, the value `mant_o`·2^(`exp_o`−23) equals 1/√X to a relative error below 2^-18, where X = (1 + `frac_i`/2^23)·2^`exp_i`.
- R3: For an operand with an odd exponent (positive or negative), the result meets the same 2^-18 relative error bound.
- R4: Whenever `done_o` is 1, bit 23 of `mant_o` (the integer bit) is 1, so the mantissa lies in [1, 2).
- R5: `exp_o` equals −floor(`exp_i`/2) − 1, or one more than that when the unscaled mantissa result reaches 2.0 and is shifted right.
- R6: Bits 22:20 of `frac_i` select one of eight segments, and the accuracy bound of R2 and R3 holds at the first and the last fraction code of every segment.
- R7: `done_o` is high for exactly one cycle, in the cycle after the eighth rising edge counted from the edge that samples `start_i`.
- R8: A `start_i` pulse that arrives while an operation is in progress is ignored. Only one `done_o` pulse results, and its value belongs to the first operand.
- R9: `mant_o` and `exp_o` change only in a cycle where `done_o` is 1, and otherwise hold their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin an operation when idle |
| frac_i | input | 23 | Operand fraction field, leading one implied |
| exp_i | input | 10 | Operand exponent, signed two's complement, unbiased |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| mant_o | output | 24 | Result mantissa, integer bit at position 23 |
| exp_o | output | 10 | Result exponent, signed two's complement |

## Verification
The embedded properties watch, on every cycle, the result's structure rather than its numeric value:
- the single-cycle completion pulse;
- the integer bit of the returned mantissa;
- the result exponent falling on the halved operand exponent or one above it;
- the captured operand staying frozen while busy;
- the outputs holding between results.

Numeric accuracy can only be shown by the bench's scenarios. These compare the returned value against a real-valued inverse square root for both parities, negative exponents, unity operands and both edges of every segment. The exact completion latency and the discarding of a mid-operation start are also shown only by scenario.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    localparam int FIX_W    = 32;
    localparam int FIX_F    = 28;
    localparam int SEG_BITS = 3;
    localparam int SEGS     = 1 << SEG_BITS;
    localparam int TERMS    = 5;
    localparam int IDX_W    = $clog2(TERMS);
    localparam int IDX_N    = 1 << IDX_W;

    typedef logic signed [FIX_W-1:0]   fix_t;
    typedef logic signed [2*FIX_W-1:0] wide_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_MAC,
        ST_SCALE,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [SEG_BITS-1:0] seg;
        fix_t                y;
        logic                odd;
    } op_t;

    function automatic real pow2r(input int e);
        real r;
        r = 1.0;
        for (int i = 0; i < e; i++) r = r * 2.0;
        for (int i = 0; i > e; i--) r = r / 2.0;
        return r;
    endfunction

    // Taylor coefficient n of x^(-1/2) about the midpoint of segment seg
    function automatic fix_t coef_val(input int seg, input int n);
        real a;
        real t;
        real b;
        a = 1.0 + (real'(seg) + 0.5) / real'(SEGS);
        t = 1.0 / $sqrt(a);
        b = 1.0;
        for (int i = 1; i <= n; i++) begin
            b = b * (0.5 - real'(i)) / real'(i);
            t = t / a;
        end
        return fix_t'($rtoi(b * t * pow2r(FIX_F)));
    endfunction

    localparam fix_t SQRT2_FIX = fix_t'($rtoi($sqrt(2.0) * pow2r(FIX_F)));

    function automatic fix_t fix_mul(input fix_t a, input fix_t b);
        wide_t p;
        p = wide_t'(a) * wide_t'(b);
        return fix_t'(p >>> FIX_F);
    endfunction

endpackage

// File: rtl/isqrt_coef_rom.sv
module isqrt_coef_rom
    import isqrt_pkg::*;
(
    input  logic [SEG_BITS-1:0] seg_i,
    input  logic [IDX_W-1:0]    idx_i,
    output fix_t                coef_o
);

    fix_t table_w [SEGS][IDX_N];

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        for (genvar n = 0; n < IDX_N; n++) begin : g_term
            if (n < TERMS) begin : g_live
                localparam fix_t C = coef_val(s, n);
                assign table_w[s][n] = C;
            end else begin : g_pad
                assign table_w[s][n] = '0;
            end
        end
    end

    assign coef_o = table_w[seg_i][idx_i];

endmodule

// File: rtl/isqrt_prep.sv
module isqrt_prep
    import isqrt_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 10
) (
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic signed [EXP_W-1:0] exp_i,
    output op_t                     op_o,
    output logic signed [EXP_W-1:0] exp_base_o
);

    localparam int REM_W = FRAC_W - SEG_BITS;
    localparam int SHIFT = FIX_F - FRAC_W;

    logic [REM_W-1:0]        rem;
    logic signed [EXP_W-1:0] half_e;

    assign rem        = frac_i[REM_W-1:0];
    assign op_o.seg   = frac_i[FRAC_W-1 -: SEG_BITS];
    assign op_o.y     = (fix_t'({1'b0, rem}) - fix_t'(1 << (REM_W - 1))) <<< SHIFT;
    assign op_o.odd   = exp_i[0];
    assign half_e     = exp_i >>> 1;
    // -floor(E/2) - 1 equals the bitwise complement of floor(E/2)
    assign exp_base_o = ~half_e;

endmodule

// File: rtl/isqrt_norm.sv
module isqrt_norm
    import isqrt_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 10
) (
    input  fix_t                    val_i,
    input  logic signed [EXP_W-1:0] exp_base_i,
    output logic [FRAC_W:0]         mant_o,
    output logic signed [EXP_W-1:0] exp_o
);

    localparam int   SHIFT = FIX_F - FRAC_W;
    localparam fix_t ONE   = fix_t'(1) <<< FRAC_W;
    localparam fix_t TWO   = fix_t'(1) <<< (FRAC_W + 1);

    fix_t m;

    always_comb begin
        m      = val_i >>> SHIFT;
        mant_o = m[FRAC_W:0];
        exp_o  = exp_base_i;
        if (m >= TWO) begin
            mant_o = m[FRAC_W+1:1];
            exp_o  = exp_base_i + {{(EXP_W-1){1'b0}}, 1'b1};
        end else if (m < ONE) begin
            mant_o = {1'b1, {FRAC_W{1'b0}}};
        end
    end

endmodule

// File: rtl/isqrt_taylor_seg.sv
module isqrt_taylor_seg
    import isqrt_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic signed [EXP_W-1:0] exp_i,
    output logic                    done_o,
    output logic [FRAC_W:0]         mant_o,
    output logic signed [EXP_W-1:0] exp_o
);

    seq_state_e              state;
    op_t                     op_q;
    op_t                     op_in;
    logic signed [EXP_W-1:0] expb_q;
    logic signed [EXP_W-1:0] expb_in;
    logic [IDX_W-1:0]        idx_q;
    fix_t                    acc;
    fix_t                    coef;
    logic [FRAC_W:0]         norm_mant;
    logic signed [EXP_W-1:0] norm_exp;

    isqrt_prep #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_prep (
        .frac_i     (frac_i),
        .exp_i      (exp_i),
        .op_o       (op_in),
        .exp_base_o (expb_in)
    );

    isqrt_coef_rom u_rom (
        .seg_i  (op_q.seg),
        .idx_i  (idx_q),
        .coef_o (coef)
    );

    isqrt_norm #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_norm (
        .val_i      (acc),
        .exp_base_i (expb_q),
        .mant_o     (norm_mant),
        .exp_o      (norm_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            expb_q <= '0;
            idx_q  <= '0;
            acc    <= '0;
            done_o <= 1'b0;
            mant_o <= '0;
            exp_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q   <= op_in;
                        expb_q <= expb_in;
                        idx_q  <= IDX_W'(TERMS - 1);
                        state  <= ST_INIT;
                    end
                end
                ST_INIT: begin
                    acc   <= coef;
                    idx_q <= idx_q - 1'b1;
                    state <= ST_MAC;
                end
                ST_MAC: begin
                    acc <= fix_mul(acc, op_q.y) + coef;
                    if (idx_q == '0) state <= ST_SCALE;
                    else             idx_q <= idx_q - 1'b1;
                end
                ST_SCALE: begin
                    acc   <= op_q.odd ? fix_mul(acc, SQRT2_FIX) : (acc <<< 1);
                    state <= ST_FIN;
                end
                ST_FIN: begin
                    mant_o <= norm_mant;
                    exp_o  <= norm_exp;
                    done_o <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R7
    AST_MANT_NORMAL: assert property (@(posedge clk) disable iff (rst) done_o |-> mant_o[FRAC_W]); // R4
    AST_EXP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (exp_o == expb_q || exp_o == expb_q + {{(EXP_W-1){1'b0}}, 1'b1})); // R5
    AST_BUSY_OP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(op_q)); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(mant_o) && $stable(exp_o))); // R9
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MAC) |-> (idx_q < IDX_W'(TERMS - 1))); // R7

endmodule

// File: tb/isqrt_taylor_seg_bench.sv
module isqrt_taylor_seg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [22:0] frac_i = '0;
    logic [9:0]  exp_i = '0;
    logic        done_o;
    logic [23:0] mant_o;
    logic [9:0]  exp_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    isqrt_taylor_seg u_isqrt_taylor_seg (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .frac_i  (frac_i),
        .exp_i   (exp_i),
        .done_o  (done_o),
        .mant_o  (mant_o),
        .exp_o   (exp_o)
    );

    function automatic real p2(input int e);
        real r;
        r = 1.0;
        for (int i = 0; i < e; i++) r = r * 2.0;
        for (int i = 0; i > e; i--) r = r / 2.0;
        return r;
    endfunction

    function automatic int floor_half(input int e);
        return (e >= 0) ? e / 2 : -((1 - e) / 2);
    endfunction

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [22:0] f, input int e,
                          output logic [23:0] m, output int ex, output int lat);
        @(negedge clk);
        frac_i  = f;
        exp_i   = 10'(e);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        m  = mant_o;
        ex = int'($signed(exp_o));
    endtask

    task automatic check_result(input string req, input logic [22:0] f, input int e);
        logic [23:0] m;
        int ex;
        int lat;
        real want;
        real got;
        real rel;
        int eb;
        run_op(f, e, m, ex, lat);
        want = 1.0 / $sqrt((1.0 + real'(f) / p2(23)) * p2(e));
        got  = real'(m) / p2(23) * p2(ex);
        rel  = (got - want) / want;
        if (rel < 0.0) rel = -rel;
        check(rel < p2(-18), req, $sformatf("%g", got), $sformatf("%g", want));
        check(m[23] == 1'b1, "R4", $sformatf("%h", m), "integer bit 1");
        eb = -floor_half(e) - 1;
        check(ex == eb || ex == eb + 1, "R5", $sformatf("%0d", ex), $sformatf("%0d or %0d", eb, eb + 1));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0 && mant_o == '0 && exp_o == '0, "R1",
              $sformatf("%b/%h/%h", done_o, mant_o, exp_o), "0/0/0");
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0 && mant_o == '0 && exp_o == '0, "R1",
              $sformatf("%b/%h/%h", done_o, mant_o, exp_o), "0/0/0");
    endtask

    task automatic t_even;
        check_result("R2", 23'h000000, 0);
        check_result("R2", 23'h000000, -2);
        check_result("R2", 23'h400000, 4);
        check_result("R2", 23'h2ABCDE, -10);
        check_result("R2", 23'h7FFFFF, 12);
    endtask

    task automatic t_odd;
        check_result("R3", 23'h000000, 1);
        check_result("R3", 23'h000000, -3);
        check_result("R3", 23'h7FFFFF, -1);
        check_result("R3", 23'h123456, 7);
        check_result("R3", 23'h6A0000, -15);
    endtask

    task automatic t_segments;
        for (int s = 0; s < 8; s++) begin
            check_result("R6", 23'(s << 20), (s % 2 == 0) ? 2 : 3);
            check_result("R6", 23'((s << 20) | 20'hFFFFF), (s % 2 == 0) ? -5 : 6);
        end
    endtask

    task automatic t_latency;
        int n_done;
        @(negedge clk);
        frac_i  = 23'h155555;
        exp_i   = 10'd2;
        start_i = 1'b1;
        n_done  = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (k == 8) check(done_o == 1'b1, "R7", $sformatf("%b at %0d", done_o, k), "1");
            else if (done_o) n_done++;
        end
        check(n_done == 0, "R7", $sformatf("%0d extra high cycles", n_done), "0");
    endtask

    task automatic t_busy_ignore;
        int n_done;
        real want;
        real got;
        real rel;
        logic [23:0] m;
        int ex;
        @(negedge clk);
        frac_i  = 23'h0F0F0F;
        exp_i   = 10'd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n_done  = 0;
        m = '0;
        ex = 0;
        for (int k = 2; k <= 20; k++) begin
            if (k == 3) begin
                frac_i  = 23'h7A0000;
                exp_i   = 10'd9;
                start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) begin
                n_done++;
                m  = mant_o;
                ex = int'($signed(exp_o));
            end
        end
        check(n_done == 1, "R8", $sformatf("%0d pulses", n_done), "1");
        want = 1.0 / $sqrt(1.0 + real'(23'h0F0F0F) / p2(23));
        got  = real'(m) / p2(23) * p2(ex);
        rel  = (got - want) / want;
        if (rel < 0.0) rel = -rel;
        check(rel < p2(-18), "R8", $sformatf("%g", got), $sformatf("%g", want));
    endtask

    task automatic t_hold;
        logic [23:0] m;
        int ex;
        int lat;
        bit same;
        run_op(23'h333333, 5, m, ex, lat);
        same = 1'b1;
        frac_i = 23'h7FFFFF;
        exp_i  = 10'd100;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (mant_o != m || int'($signed(exp_o)) != ex) same = 1'b0;
        end
        check(same, "R9", $sformatf("%h/%0d", mant_o, $signed(exp_o)), $sformatf("%h/%0d", m, ex));
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_even();
        t_odd();
        t_segments();
        t_latency();
        t_busy_ignore();
        t_hold();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule